// File: doc/BRIEF.md
# Three-Level Quasi-Sine Generator

This block turns a phase word, typically the upper bits of a numerically controlled oscillator's accumulator, into a three-level stepped waveform that tracks the oscillator cycle for cycle. Each phase cycle is cut into six equal sixths. The output sits at +1 for two sixths, rests at 0 for one sixth, sits at −1 for two sixths and rests at 0 for the last sixth. With these exact proportions the waveform carries no third harmonic, and its fifth and seventh harmonics are smaller than those of a square wave. That makes it a cheap reference or drive signal for a loop or a bridge.

The block gives the level as a small signed code for digital consumers. It also gives two drive enables, one for the high switch and one for the low switch of a bridge. A programmable dead time holds back each enable's rising edge so the two switches never conduct together. A run input parks the output at zero, and the waveform resumes from whatever sixth the live phase is in.

Top module: `tri_level_wavegen`

## Requirements
- R1: With run high, a phase value below B1 = floor(2·2^16/6) = 21845 gives level code 2'b01 (+1) one clock later.
- R2: With run high, a phase value from B1 up to but not including B2 = 2^16/2 = 32768 gives level code 2'b00 (0) one clock later.
- R3: With run high, a phase value from B2 up to but not including B3 = floor(5·2^16/6) = 54613 gives level code 2'b11 (−1) one clock later.
- R4: With run high, a phase value of B3 or above gives level code 2'b00 (0) one clock later.
- R5: The level output is registered. It reflects the phase and run sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R6: While run is low, the level goes to 2'b00 and both drive enables go low one clock later. When run returns high, the next level is the one the current phase selects.
- R7: drive_hi is high only while the level is +1, drive_lo is high only while the level is −1, and the two are never high together.
- R8: A drive enable rises D clocks after the level enters its matching segment, where D is the dead_cycles value (0 to 255) sampled at each edge. With D = 0 the enable rises on the same edge as the level. If the segment lasts fewer than D+1 clocks, the enable stays low.
- R9: A drive enable falls on the same clock edge on which the level leaves its matching segment.
- R10: After a synchronous reset the level is 2'b00 and both enables are low. The code 2'b10 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to generate the waveform, low to force zero |
| phase_in | input | 16 | Phase word, full scale is one waveform period |
| dead_cycles | input | 8 | Dead time D in clocks applied to each rising enable |
| level_out | output | 2 | Signed level code: 01 = +1, 00 = 0, 11 = −1 |
| drive_hi | output | 1 | High-side switch enable |
| drive_lo | output | 1 | Low-side switch enable |

## Verification
The assertions rest on the decoded segments being mutually exclusive, so the high and low requests can never coincide whatever the phase does. The dead-time property also needs dead_cycles to be sampled per edge with no settling assumption. The stimulus sweeps every phase value in order, then walks the phase in coarse and odd strides. During those walks dead_cycles changes mid-segment, run toggles in the middle of segments, and the phase jumps straight from the +1 region into the −1 region. Every input changes only on the falling clock edge, so each value is stable at the sampling edge, as the properties take for granted.

// File: rtl/qsg_pkg.sv
package qsg_pkg;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        SEG_POS   = 2'd0,
        SEG_GAP_A = 2'd1,
        SEG_NEG   = 2'd2,
        SEG_GAP_B = 2'd3
    } seg_e;

    typedef struct packed {
        logic hi_req;
        logic lo_req;
    } leg_req_t;

    // num/6 of a full scale of 2^w, rounded down
    function automatic logic [63:0] sixths_of_scale(input int unsigned num,
                                                     input int unsigned w);
        return (64'(num) << w) / 64'd6;
    endfunction

    function automatic level_e seg_to_level(input seg_e s);
        case (s)
            SEG_POS: return LVL_POS;
            SEG_NEG: return LVL_NEG;
            default: return LVL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/qsg_segment_decode.sv
module qsg_segment_decode
    import qsg_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0] phase,
    output seg_e               seg
);
    localparam int CMP_W = PHASE_W + 1;
    localparam logic [CMP_W-1:0] EDGE_POS_END = CMP_W'(sixths_of_scale(2, PHASE_W));
    localparam logic [CMP_W-1:0] EDGE_NEG_BEG = CMP_W'(sixths_of_scale(3, PHASE_W));
    localparam logic [CMP_W-1:0] EDGE_NEG_END = CMP_W'(sixths_of_scale(5, PHASE_W));

    logic [CMP_W-1:0] ph_ext;
    assign ph_ext = {1'b0, phase};

    always_comb begin
        if (ph_ext < EDGE_POS_END)
            seg = SEG_POS;
        else if (ph_ext < EDGE_NEG_BEG)
            seg = SEG_GAP_A;
        else if (ph_ext < EDGE_NEG_END)
            seg = SEG_NEG;
        else
            seg = SEG_GAP_B;
    end
endmodule

// File: rtl/qsg_level_stage.sv
module qsg_level_stage
    import qsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  seg_e     seg,
    output level_e   level_q,
    output leg_req_t req_nxt
);
    level_e level_nxt;

    always_comb begin
        level_nxt      = run ? seg_to_level(seg) : LVL_ZERO;
        req_nxt.hi_req = (level_nxt == LVL_POS);
        req_nxt.lo_req = (level_nxt == LVL_NEG);
    end

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= LVL_ZERO;
        else
            level_q <= level_nxt;
    end

    // R10: only the three legal codes leave this stage
    p_legal_code_r10: assert property (@(posedge clk) disable iff (rst)
        level_q != 2'b10);

    // R6: a low run seen at an edge yields zero after it
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> level_q == LVL_ZERO);
endmodule

// File: rtl/qsg_leg_delay.sv
module qsg_leg_delay #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [DT_W-1:0] dead_time,
    output logic            en
);
    localparam logic [DT_W-1:0] HOLD_MAX = {DT_W{1'b1}};

    logic [DT_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            en   <= 1'b0;
        end else if (req) begin
            if (held != HOLD_MAX)
                held <= held + 1'b1;
            en <= (held >= dead_time);
        end else begin
            held <= '0;
            en   <= 1'b0;
        end
    end

    // R8: with a nonzero dead time the request was present for at least two edges
    p_rise_waits_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(en) && ($past(dead_time) != '0)) |-> $past(req, 2));

    // R9: the enable never outlives its request
    p_drop_with_req_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(req) |-> !en);
endmodule

// File: rtl/tri_level_wavegen.sv
module tri_level_wavegen
    import qsg_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int DT_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [DT_W-1:0]    dead_cycles,
    output logic [1:0]         level_out,
    output logic               drive_hi,
    output logic               drive_lo
);
    localparam int N_LEGS = 2;

    seg_e          seg;
    level_e        level_q;
    leg_req_t      req_nxt;
    logic [N_LEGS-1:0] leg_req;
    logic [N_LEGS-1:0] leg_en;

    qsg_segment_decode #(.PHASE_W(PHASE_W)) decode_i (
        .phase (phase_in),
        .seg   (seg)
    );

    qsg_level_stage level_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .seg     (seg),
        .level_q (level_q),
        .req_nxt (req_nxt)
    );

    assign leg_req = {req_nxt.lo_req, req_nxt.hi_req};

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        qsg_leg_delay #(.DT_W(DT_W)) leg_i (
            .clk       (clk),
            .rst       (rst),
            .req       (leg_req[g]),
            .dead_time (dead_cycles),
            .en        (leg_en[g])
        );
    end

    assign level_out = level_q;
    assign drive_hi  = leg_en[0];
    assign drive_lo  = leg_en[1];

    // R7: both switches are never enabled together
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        !(drive_hi && drive_lo));

    // R7: each enable agrees with the level it drives
    p_hi_on_pos_r7: assert property (@(posedge clk) disable iff (rst)
        drive_hi |-> level_q == LVL_POS);

    p_lo_on_neg_r7: assert property (@(posedge clk) disable iff (rst)
        drive_lo |-> level_q == LVL_NEG);

    // R6: idle forces both enables low
    p_idle_off_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (!drive_hi && !drive_lo));
endmodule

// File: tb/tri_level_wavegen_tb_top.sv
module tri_level_wavegen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [15:0] phase_in = '0;
    logic [7:0]  dead_cycles = '0;
    logic [1:0]  level_out;
    logic        drive_hi;
    logic        drive_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // model state
    int    exp_lvl  = 0;
    bit    exp_hi   = 1'b0;
    bit    exp_lo   = 1'b0;
    int    hi_len   = 0;
    int    lo_len   = 0;
    string lvl_tag  = "R10";

    localparam int FULL = 65536;
    localparam int B1   = (2 * FULL) / 6;
    localparam int B2   = (3 * FULL) / 6;
    localparam int B3   = (5 * FULL) / 6;

    always #4 clk = ~clk;

    tri_level_wavegen dut_i (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .phase_in    (phase_in),
        .dead_cycles (dead_cycles),
        .level_out   (level_out),
        .drive_hi    (drive_hi),
        .drive_lo    (drive_lo)
    );

    function automatic int code_of(input int ph, input bit rn);
        if (!rn)        return 0;
        if (ph < B1)    return 1;
        if (ph < B2)    return 0;
        if (ph < B3)    return 3;
        return 0;
    endfunction

    function automatic string tag_of(input int ph, input bit rn);
        if (!rn)        return "R6/R5";
        if (ph < B1)    return "R1/R5";
        if (ph < B2)    return "R2/R5";
        if (ph < B3)    return "R3/R5";
        return "R4/R5";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        check(lvl_tag, int'(level_out), exp_lvl);
        check("R8/R9 drive_hi", int'(drive_hi), int'(exp_hi));
        check("R8/R9 drive_lo", int'(drive_lo), int'(exp_lo));
        check("R7 overlap", int'(drive_hi && drive_lo), 0);
        check("R10 illegal code", int'(level_out == 2'b10), 0);
    endtask

    // check the last edge's result, then apply the next inputs
    task automatic step(input int ph, input bit rn, input int dt);
        @(negedge clk);
        compare_outputs();
        phase_in    = 16'(ph);
        run         = rn;
        dead_cycles = 8'(dt);
        exp_lvl = code_of(ph, rn);
        lvl_tag = tag_of(ph, rn);
        if (exp_lvl == 1) hi_len++; else hi_len = 0;
        if (exp_lvl == 3) lo_len++; else lo_len = 0;
        exp_hi = (exp_lvl == 1) && (hi_len - 1 >= dt);
        exp_lo = (exp_lvl == 3) && (lo_len - 1 >= dt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset level", int'(level_out), 0);
        check("R10 reset hi", int'(drive_hi), 0);
        check("R10 reset lo", int'(drive_lo), 0);
        rst = 1'b0;

        // full phase sweep, no dead time: R1 R2 R3 R4 boundaries included
        for (int p = 0; p < FULL; p++) step(p, 1'b1, 0);

        // explicit boundary pairs around each segment edge
        step(B1 - 1, 1'b1, 0); step(B1, 1'b1, 0);
        step(B2 - 1, 1'b1, 0); step(B2, 1'b1, 0);
        step(B3 - 1, 1'b1, 0); step(B3, 1'b1, 0);
        step(FULL - 1, 1'b1, 0); step(0, 1'b1, 0);

        // maximum dead time, coarse stride: R8 with D = 255
        for (int i = 0; i < 3072; i++) step((i * 64) % FULL, 1'b1, 255);

        // odd stride with dead time changing mid-segment: R8 R9
        for (int i = 0; i < 4000; i++) step((i * 37) % FULL, 1'b1, ((i / 500) * 7) % 256);

        // run toggling inside segments: R6
        for (int i = 0; i < 3000; i++) step((i * 13) % FULL, ((i / 50) % 3) != 0, 2);

        // direct jumps between +1 and -1 regions: R7 R9
        for (int i = 0; i < 20; i++) step((i % 2 == 0) ? 1000 : 40000, 1'b1, 0);
        for (int i = 0; i < 20; i++) step((i % 2 == 0) ? 1000 : 40000, 1'b1, 1);
        for (int i = 0; i < 10; i++) step(40000, 1'b1, 3);
        for (int i = 0; i < 5; i++)  step(1000, 1'b1, 0);

        step(0, 1'b0, 0);
        step(0, 1'b0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule